// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block is a direct-mapped branch target buffer for an instruction fetch pipeline. Each slot remembers which branch it belongs to, where that branch went the last time it was taken, and a two-bit confidence counter of its recent outcomes. The fetch stage presents an address on the lookup channel and, in the same cycle, learns whether the buffer knows that address, whether the branch is expected to be taken and where it is expected to go.

When a branch resolves further down the pipe, the resolution stage presents the branch address, its real direction and real destination, together with the prediction it was given at lookup time. The block refreshes or allocates the slot and, if the prediction was wrong in direction or destination, raises a flush request for a fixed number of cycles. While the flush request is high the lookup channel applies back-pressure: `lk_ready` is low and no lookup is accepted. A lookup transfers on a cycle where `lk_valid` and `lk_ready` are both high; the lookup results are meaningful only on such a cycle and read as zero otherwise. The update channel is a plain valid strobe that is always accepted, so resolution never stalls.

Top module: `btb_predictor`

## Requirements
- R1: After reset every slot is empty: any lookup returns `lk_hit`=0, `lk_taken`=0, `lk_target`=0 until a taken branch has been written.
- R2: The slot index is `pc[9:2]`; all other address bits form the tag. A lookup whose tag differs from the stored one (e.g. an address 0x400 away, same index) is a miss and predicts not taken with target 0.
- R3: A resolved taken branch that misses allocates its slot with counter value 2, so the next lookup of that address hits, predicts taken and returns the resolved target.
- R4: A resolved not-taken branch that misses allocates nothing; a later lookup of that address still misses.
- R5: On a hit, the counter counts up on taken and down on not taken, saturating at 3 and 0; values 2 and 3 predict taken, values 0 and 1 predict not taken (still with `lk_hit`=1).
- R6: A taken update that hits replaces the stored target; a not-taken update that hits keeps the stored target.
- R7: An update whose real direction differs from `up_pred_taken`, or which is taken with `up_target` different from `up_pred_target`, raises `flush` from the next cycle for exactly 4 cycles (parameter `FLUSH_CYC`); a correct update raises no flush. A new mispredict restarts the window.
- R8: While `flush` is high, `lk_ready` is low and lookup outputs read zero; otherwise `lk_ready` is high.
- R9: A lookup and an update in the same cycle see the slot contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup accepted this cycle (low during flush) |
| lk_pc | input | 32 | Fetch address to look up |
| lk_hit | output | 1 | Address found in the buffer |
| lk_taken | output | 1 | Branch predicted taken |
| lk_target | output | 32 | Predicted destination (0 on a miss) |
| up_valid | input | 1 | Resolved branch present |
| up_pc | input | 32 | Resolved branch address |
| up_taken | input | 1 | Real direction |
| up_target | input | 32 | Real destination |
| up_pred_taken | input | 1 | Direction predicted at lookup |
| up_pred_target | input | 32 | Destination predicted at lookup |
| flush | output | 1 | Pipeline flush request |

## Verification
The hardest corners to reach are the counter extremes, because each step toward 0 or 3 from the allocation value needs its own resolved update and every step that crosses the taken threshold also opens a flush window that blocks lookups. The stimulus walks one slot down to 0, past the floor, back up through the threshold to 3 and past the ceiling, looking the slot up between steps and waiting out each flush window. An aliasing address with the same index and a lookup issued in the very cycle of an allocating update cover the tag compare and the read-before-write ordering.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_ALLOC = 2'd2;

  function automatic ctr_t ctr_step(input ctr_t c, input logic up);
    ctr_t r;
    if (up) r = (c == 2'd3) ? c : c + 2'd1;
    else    r = (c == 2'd0) ? c : c - 2'd1;
    return r;
  endfunction

  function automatic logic ctr_says_taken(input ctr_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int TAG_W   = 24,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic              rd_a_vld,
  output logic [TAG_W-1:0]  rd_a_tag,
  output logic [ADDR_W-1:0] rd_a_tgt,
  output ctr_t              rd_a_ctr,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic              rd_b_vld,
  output logic [TAG_W-1:0]  rd_b_tag,
  output logic [ADDR_W-1:0] rd_b_tgt,
  output ctr_t              rd_b_ctr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_tgt,
  input  ctr_t              wr_ctr
);

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q [ENTRIES];
  ctr_t               ctr_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      tgt_q[wr_idx] <= wr_tgt;
      ctr_q[wr_idx] <= wr_ctr;
    end
  end

  assign rd_a_vld = vld_q[rd_a_idx];
  assign rd_a_tag = tag_q[rd_a_idx];
  assign rd_a_tgt = tgt_q[rd_a_idx];
  assign rd_a_ctr = ctr_q[rd_a_idx];
  assign rd_b_vld = vld_q[rd_b_idx];
  assign rd_b_tag = tag_q[rd_b_idx];
  assign rd_b_tgt = tgt_q[rd_b_idx];
  assign rd_b_ctr = ctr_q[rd_b_idx];

endmodule

// File: rtl/btb_resolve.sv
module btb_resolve
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 24
) (
  input  logic              up_valid,
  input  logic              up_taken,
  input  logic [ADDR_W-1:0] up_target,
  input  logic              up_pred_taken,
  input  logic [ADDR_W-1:0] up_pred_target,
  input  logic [TAG_W-1:0]  up_tag,
  input  logic              slot_vld,
  input  logic [TAG_W-1:0]  slot_tag,
  input  logic [ADDR_W-1:0] slot_tgt,
  input  ctr_t              slot_ctr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_tgt,
  output ctr_t              wr_ctr,
  output logic              mispredict
);

  logic slot_match;
  logic dir_wrong;
  logic dst_wrong;

  assign slot_match = slot_vld && (slot_tag == up_tag);

  always_comb begin
    wr_en  = 1'b0;
    wr_tgt = slot_tgt;
    wr_ctr = slot_ctr;
    if (up_valid) begin
      if (slot_match) begin
        wr_en  = 1'b1;
        wr_ctr = ctr_step(slot_ctr, up_taken);
        if (up_taken) wr_tgt = up_target;
      end else if (up_taken) begin
        wr_en  = 1'b1;
        wr_ctr = CTR_ALLOC;
        wr_tgt = up_target;
      end
    end
  end

  assign dir_wrong  = up_taken != up_pred_taken;
  assign dst_wrong  = up_taken && (up_target != up_pred_target);
  assign mispredict = up_valid && (dir_wrong || dst_wrong);

endmodule

// File: rtl/btb_flush_ctl.sv
module btb_flush_ctl #(
  parameter int FLUSH_CYC = 4,
  localparam int CNT_W    = $clog2(FLUSH_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mispredict,
  output logic flush
);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               left_q <= '0;
    else if (mispredict)      left_q <= CNT_W'(FLUSH_CYC);
    else if (left_q != '0)    left_q <= left_q - 1'b1;
  end

  assign flush = left_q != '0;

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int ENTRIES   = 256,
  parameter int OFS_W     = 2,
  parameter int FLUSH_CYC = 4,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int TAG_W    = ADDR_W - IDX_W,
  localparam int IDX_LO   = OFS_W,
  localparam int IDX_HI   = OFS_W + IDX_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_hit,
  output logic              lk_taken,
  output logic [ADDR_W-1:0] lk_target,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_pc,
  input  logic              up_taken,
  input  logic [ADDR_W-1:0] up_target,
  input  logic              up_pred_taken,
  input  logic [ADDR_W-1:0] up_pred_target,
  output logic              flush
);

  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [TAG_W-1:0]  lk_tag, up_tag;
  logic              a_vld, b_vld;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [ADDR_W-1:0] a_tgt, b_tgt;
  ctr_t              a_ctr, b_ctr;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_tgt;
  ctr_t              wr_ctr;
  logic              mispredict;
  logic              lk_fire;
  logic              lk_match;

  assign lk_idx = lk_pc[IDX_HI:IDX_LO];
  assign up_idx = up_pc[IDX_HI:IDX_LO];

  generate
    if (OFS_W > 0) begin : g_tag_ofs
      assign lk_tag = {lk_pc[ADDR_W-1:IDX_HI+1], lk_pc[OFS_W-1:0]};
      assign up_tag = {up_pc[ADDR_W-1:IDX_HI+1], up_pc[OFS_W-1:0]};
    end else begin : g_tag_plain
      assign lk_tag = lk_pc[ADDR_W-1:IDX_HI+1];
      assign up_tag = up_pc[ADDR_W-1:IDX_HI+1];
    end
  endgenerate

  btb_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (lk_idx),
    .rd_a_vld (a_vld),
    .rd_a_tag (a_tag),
    .rd_a_tgt (a_tgt),
    .rd_a_ctr (a_ctr),
    .rd_b_idx (up_idx),
    .rd_b_vld (b_vld),
    .rd_b_tag (b_tag),
    .rd_b_tgt (b_tgt),
    .rd_b_ctr (b_ctr),
    .wr_en    (wr_en),
    .wr_idx   (up_idx),
    .wr_tag   (up_tag),
    .wr_tgt   (wr_tgt),
    .wr_ctr   (wr_ctr)
  );

  btb_resolve #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_resolve (
    .up_valid       (up_valid),
    .up_taken       (up_taken),
    .up_target      (up_target),
    .up_pred_taken  (up_pred_taken),
    .up_pred_target (up_pred_target),
    .up_tag         (up_tag),
    .slot_vld       (b_vld),
    .slot_tag       (b_tag),
    .slot_tgt       (b_tgt),
    .slot_ctr       (b_ctr),
    .wr_en          (wr_en),
    .wr_tgt         (wr_tgt),
    .wr_ctr         (wr_ctr),
    .mispredict     (mispredict)
  );

  btb_flush_ctl #(.FLUSH_CYC(FLUSH_CYC)) u_flush (
    .clk        (clk),
    .rst_n      (rst_n),
    .mispredict (mispredict),
    .flush      (flush)
  );

  assign lk_ready  = !flush;
  assign lk_fire   = lk_valid && lk_ready;
  assign lk_match  = lk_fire && a_vld && (a_tag == lk_tag);
  assign lk_hit    = lk_match;
  assign lk_taken  = lk_match && ctr_says_taken(a_ctr);
  assign lk_target = lk_match ? a_tgt : '0;

endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
  parameter int ADDR_W    = 32,
  parameter int FLUSH_CYC = 4,
  localparam int Q_W      = $clog2(FLUSH_CYC + 2)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_ready,
  input logic              lk_hit,
  input logic              lk_taken,
  input logic [ADDR_W-1:0] lk_target,
  input logic              up_valid,
  input logic              up_taken,
  input logic [ADDR_W-1:0] up_target,
  input logic              up_pred_taken,
  input logic [ADDR_W-1:0] up_pred_target,
  input logic              flush
);

  logic           wrong_in;
  logic           alloc_seen;
  logic [Q_W-1:0] since_mp;

  assign wrong_in = up_valid && ((up_taken != up_pred_taken) ||
                    (up_taken && (up_target != up_pred_target)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alloc_seen <= 1'b0;
      since_mp   <= Q_W'(FLUSH_CYC);
    end else begin
      if (up_valid && up_taken) alloc_seen <= 1'b1;
      if (wrong_in) since_mp <= '0;
      else if (since_mp < Q_W'(FLUSH_CYC)) since_mp <= since_mp + 1'b1;
    end
  end

  p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_seen |-> !lk_hit);

  p_miss_predicts_nothing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (!lk_taken && lk_target == '0));

  p_flush_follows_wrong_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrong_in |=> flush);

  p_flush_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush == (since_mp < Q_W'(FLUSH_CYC)));

  p_backpressure_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_ready == !flush);

  p_quiet_during_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !lk_hit);

endmodule

bind btb_predictor btb_predictor_chk #(.ADDR_W(ADDR_W), .FLUSH_CYC(FLUSH_CYC)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .lk_ready       (lk_ready),
  .lk_hit         (lk_hit),
  .lk_taken       (lk_taken),
  .lk_target      (lk_target),
  .up_valid       (up_valid),
  .up_taken       (up_taken),
  .up_target      (up_target),
  .up_pred_taken  (up_pred_taken),
  .up_pred_target (up_pred_target),
  .flush          (flush)
);

// File: tb/btb_predictor_test.sv
module btb_predictor_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_pc = '0;
  logic        lk_hit, lk_taken;
  logic [31:0] lk_target;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic        up_taken = 1'b0;
  logic [31:0] up_target = '0;
  logic        up_pred_taken = 1'b0;
  logic [31:0] up_pred_target = '0;
  logic        flush;

  always #5 clk = ~clk;

  btb_predictor uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_pc(lk_pc),
    .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_target(lk_target),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
    .up_target(up_target), .up_pred_taken(up_pred_taken),
    .up_pred_target(up_pred_target), .flush(flush)
  );

  typedef struct packed {
    logic        hit;
    logic        tk;
    logic [31:0] tgt;
  } exp_t;

  exp_t  exp_q[$];
  string req_q[$];
  int    errors = 0;
  int    checks = 0;
  bit    done   = 1'b0;

  localparam logic [31:0] PA = 32'h0000_1234;
  localparam logic [31:0] PB = 32'h0000_1634;
  localparam logic [31:0] PC = 32'h0000_2238;
  localparam logic [31:0] T1 = 32'h0000_8000;
  localparam logic [31:0] T2 = 32'h0000_9000;
  localparam logic [31:0] T3 = 32'h0000_A000;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: pops one expected result per accepted lookup
  always @(negedge clk) begin
    #2;
    if (lk_valid && lk_ready) begin
      if (exp_q.size() == 0) begin
        check("R8", "unexpected lookup accepted", 32'd1, 32'd0);
      end else begin
        exp_t  e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(r, "lk_hit", {31'd0, lk_hit}, {31'd0, e.hit});
        check(r, "lk_taken", {31'd0, lk_taken}, {31'd0, e.tk});
        check(r, "lk_target", lk_target, e.tgt);
      end
    end
  end

  task automatic look(input logic [31:0] pc, input logic h, input logic t,
                      input logic [31:0] tg, input string req);
    exp_t e;
    @(negedge clk);
    while (!lk_ready) @(negedge clk);
    e.hit = h; e.tk = t; e.tgt = tg;
    exp_q.push_back(e);
    req_q.push_back(req);
    lk_valid = 1'b1;
    lk_pc    = pc;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic upd(input logic [31:0] pc, input logic tk, input logic [31:0] tg,
                     input logic ptk, input logic [31:0] ptg);
    @(negedge clk);
    up_valid = 1'b1; up_pc = pc; up_taken = tk; up_target = tg;
    up_pred_taken = ptk; up_pred_target = ptg;
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  // called at the negedge right after the update's write edge
  task automatic expect_flush(input logic wrong, input string req);
    if (wrong) begin
      for (int i = 0; i <= 4; i++) begin
        #1;
        check(req, $sformatf("flush cycle %0d", i), {31'd0, flush},
              {31'd0, (i < 4) ? 1'b1 : 1'b0});
        check("R8", $sformatf("lk_ready cycle %0d", i), {31'd0, lk_ready},
              {31'd0, (i < 4) ? 1'b0 : 1'b1});
        @(negedge clk);
      end
    end else begin
      #1;
      check(req, "no flush", {31'd0, flush}, 32'd0);
      check("R8", "ready without flush", {31'd0, lk_ready}, 32'd1);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "flush after reset", {31'd0, flush}, 32'd0);
    check("R8", "ready after reset", {31'd0, lk_ready}, 32'd1);
    look(PA, 0, 0, 32'd0, "R1");
    look(PC, 0, 0, 32'd0, "R1");

    // R4: not-taken miss allocates nothing
    upd(PA, 1'b0, 32'd0, 1'b0, 32'd0);
    expect_flush(1'b0, "R7");
    look(PA, 0, 0, 32'd0, "R4");

    // R3: taken miss allocates at counter 2; R7 direction wrong
    upd(PA, 1'b1, T1, 1'b0, 32'd0);
    expect_flush(1'b1, "R7");
    look(PA, 1, 1, T1, "R3");
    // R2: alias with same index, other tag
    look(PB, 0, 0, 32'd0, "R2");

    // R5/R6: count down to floor, target kept
    upd(PA, 1'b0, 32'd0, 1'b1, T1);     // ctr 1
    expect_flush(1'b1, "R7");
    look(PA, 1, 0, T1, "R6");
    upd(PA, 1'b0, 32'd0, 1'b0, 32'd0);  // ctr 0
    expect_flush(1'b0, "R7");
    upd(PA, 1'b0, 32'd0, 1'b0, 32'd0);  // floor stays 0
    expect_flush(1'b0, "R7");
    upd(PA, 1'b1, T2, 1'b0, 32'd0);     // ctr 1, target T2
    expect_flush(1'b1, "R7");
    look(PA, 1, 0, T2, "R5");
    upd(PA, 1'b1, T2, 1'b0, 32'd0);     // ctr 2
    expect_flush(1'b1, "R7");
    look(PA, 1, 1, T2, "R5");
    upd(PA, 1'b1, T2, 1'b1, T2);        // ctr 3, correct
    expect_flush(1'b0, "R7");
    upd(PA, 1'b1, T2, 1'b1, T2);        // ceiling stays 3
    expect_flush(1'b0, "R7");
    upd(PA, 1'b0, 32'd0, 1'b1, T2);     // ctr 2
    expect_flush(1'b1, "R7");
    look(PA, 1, 1, T2, "R5");

    // R7 destination wrong, R6 target replaced
    upd(PA, 1'b1, T3, 1'b1, T2);        // ctr 3
    expect_flush(1'b1, "R7");
    look(PA, 1, 1, T3, "R6");
    look(PB, 0, 0, 32'd0, "R2");

    // R9: lookup in the cycle of an allocating update sees the old slot
    begin
      exp_t e;
      @(negedge clk);
      e.hit = 1'b0; e.tk = 1'b0; e.tgt = 32'd0;
      exp_q.push_back(e);
      req_q.push_back("R9");
      lk_valid = 1'b1; lk_pc = PC;
      up_valid = 1'b1; up_pc = PC; up_taken = 1'b1; up_target = T1;
      up_pred_taken = 1'b0; up_pred_target = 32'd0;
      @(negedge clk);
      lk_valid = 1'b0; up_valid = 1'b0;
      expect_flush(1'b1, "R7");
    end
    look(PC, 1, 1, T1, "R9");

    // R7: a second mispredict inside the window restarts it
    upd(PC, 1'b0, 32'd0, 1'b1, T1);
    repeat (2) @(negedge clk);
    upd(PC, 1'b1, T2, 1'b0, 32'd0);
    expect_flush(1'b1, "R7");

    repeat (2) @(negedge clk);
    check("R8", "scoreboard drained", exp_q.size(), 32'd0);
    finish_run();
  end

endmodule